// File: doc/BRIEF.md
# Two-Sided Byte Mailbox

This block is a small register file shared by a local processor and a remote host. Each side has its own plain register port: an address, a write strobe with write data, and a read strobe whose data comes back one cycle later. Sixteen byte-wide message registers can be read and written from either port. They sit on a 4-byte stride, and the upper three bytes of each word are reserved.

Two doorbells carry signalling between the sides. A local control register has three bits: a received flag, set when the remote side rings, an interrupt mask, and a send bit that raises a doorbell output toward the remote side. That doorbell stays up until the remote side acknowledges it. Per-register enable bits let a remote write to a chosen message register set a write-one-to-clear status bit. The local interrupt line combines the unmasked received flag with any enabled status bit.

Top module: `byte_mailbox`

## Requirements
- R1: After a synchronous reset all message, status, enable and control state is zero, and `loc_irq` and `rem_doorbell` are 0.
- R2: Message register i (0..15) is at byte offset 4*i on both ports. Its value reads back in bits [7:0], and bits [31:8] read as zero. An access whose address has bits [1:0] not equal to zero is ignored, and so are write data bits [31:8].
- R3: When both ports write the same message register in the same cycle, the remote value is stored.
- R4: A remote write to message register i sets status bit i%8 of the status word at local offset 0x40 (i<8) or 0x44 (i>=8), but only if the matching enable bit is set. Local writes to message registers never set status.
- R5: A local write to 0x40 or 0x44 clears each status bit whose data bit is 1 and leaves the others. If a set and a clear hit the same bit in one cycle, the bit ends up set.
- R6: The enable words at local offsets 0x50 (registers 0..7) and 0x54 (registers 8..15) are readable and writable, 8 bits each, and use the same bit order as the status words.
- R7: A local write to control offset 0x48 with bit 0 set raises `rem_doorbell` at the same edge. It stays high until the remote side writes offset 0x4C with bit 7 set. In a tie, the set wins.
- R8: A remote write to 0x4C with bit 0 set sets the received flag, which is bit 7 of the local control word. A local control write with bit 7 clear leaves the flag unchanged. So does writing 0x02, which only sets the mask (bit 1).
- R9: A local control write of 0x80 clears the received flag and the mask bit in the same cycle. A remote ring in that same cycle wins for the flag.
- R10: `loc_irq` is registered. It equals (received AND NOT mask) OR (any status bit whose enable is set), one clock after that state changes.
- R11: Read data is registered and valid the cycle after the read strobe. Both ports read 0x4C as {doorbell pending at bit 7, received flag at bit 0}. The local port reads 0x48 as {received bit 7, mask bit 1, doorbell pending bit 0}. Unmapped offsets read zero, and the remote port sees only the message registers and 0x4C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_addr | input | 7 | Local byte address |
| loc_wr | input | 1 | Local write strobe |
| loc_wdata | input | 32 | Local write data |
| loc_rd | input | 1 | Local read strobe |
| loc_rdata | output | 32 | Local read data, one cycle after strobe |
| rem_addr | input | 7 | Remote byte address |
| rem_wr | input | 1 | Remote write strobe |
| rem_wdata | input | 32 | Remote write data |
| rem_rd | input | 1 | Remote read strobe |
| rem_rdata | output | 32 | Remote read data, one cycle after strobe |
| loc_irq | output | 1 | Local interrupt |
| rem_doorbell | output | 1 | Doorbell pending toward the remote side |

## Verification
The hardest situations to reach are the same-cycle collisions: both ports writing one message register, a remote status set meeting a local clear of that bit, and a remote ring meeting the local unmask-and-clear write. Ordinary sequential traffic never produces these. The bench drives both ports within a single clock phase to create each collision directly, then reads the outcome back through the register map. A seeded random phase mixes writes from both ports against random enable masks and compares every message register, status word and the interrupt line with a model.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int BANK_W = 8;

  localparam logic [ADDR_W-1:0] OFS_STAT = 7'h40;
  localparam logic [ADDR_W-1:0] OFS_LCTL = 7'h48;
  localparam logic [ADDR_W-1:0] OFS_RCTL = 7'h4C;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 7'h50;

  localparam int LCTL_RCV  = 7;
  localparam int LCTL_MASK = 1;
  localparam int LCTL_BELL = 0;
  localparam int RCTL_ACK  = 7;
  localparam int RCTL_RING = 0;
endpackage

// File: rtl/mbox_data_regs.sv
module mbox_data_regs #(
  parameter int NUM_REGS = 16,
  parameter int BYTE_W   = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_we,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [BYTE_W-1:0] a_wdata,
  input  logic              b_we,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic [BYTE_W-1:0] b_wdata,
  output logic [BYTE_W-1:0] a_rbyte,
  output logic [BYTE_W-1:0] b_rbyte
);
  logic [BYTE_W-1:0] mem [NUM_REGS];

  // Port b (remote) is written last so it wins a same-index collision.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else begin
      if (a_we) mem[a_idx] <= a_wdata;
      if (b_we) mem[b_idx] <= b_wdata;
    end
  end

  assign a_rbyte = mem[a_idx];
  assign b_rbyte = mem[b_idx];

  // R3: remote write wins on collision
  a_r3_remote_wins: assert property (@(posedge clk) disable iff (rst)
    (a_we && b_we && a_idx == b_idx) |=> (mem[$past(b_idx)] == $past(b_wdata)));
endmodule

// File: rtl/mbox_irq_status.sv
module mbox_irq_status #(
  parameter int NUM_REGS = 16,
  parameter int BANK_W   = 8,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int BANKS   = NUM_REGS / BANK_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                set_we,
  input  logic [IDX_W-1:0]    set_idx,
  input  logic [NUM_REGS-1:0] clr_mask,
  input  logic [BANKS-1:0]    en_we,
  input  logic [BANK_W-1:0]   en_wdata,
  output logic [NUM_REGS-1:0] status,
  output logic [NUM_REGS-1:0] enable,
  output logic                pend
);
  logic [NUM_REGS-1:0] set_vec;

  always_comb begin
    set_vec = '0;
    if (set_we && enable[set_idx]) set_vec[set_idx] = 1'b1;
  end

  // Set takes priority over a same-cycle clear.
  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~clr_mask) | set_vec;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)           enable[b*BANK_W +: BANK_W] <= '0;
      else if (en_we[b]) enable[b*BANK_W +: BANK_W] <= en_wdata;
    end
  end

  assign pend = |(status & enable);

  // R4: enabled remote write raises status
  a_r4_status_set: assert property (@(posedge clk) disable iff (rst)
    (set_we && enable[set_idx]) |=> status[$past(set_idx)]);
  // R4: disabled register never raises status
  a_r4_no_set_disabled: assert property (@(posedge clk) disable iff (rst)
    (set_we && !enable[set_idx] && !status[set_idx]) |=> !status[$past(set_idx)]);
  // R5: write-one-to-clear without a competing set
  a_r5_w1c: assert property (@(posedge clk) disable iff (rst)
    (clr_mask != '0 && !set_we) |=> ((status & $past(clr_mask)) == '0));
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic loc_we,
  input  logic loc_clr_rcv,
  input  logic loc_mask_val,
  input  logic loc_send,
  input  logic rem_we,
  input  logic rem_ring,
  input  logic rem_ack,
  output logic rcv,
  output logic mask,
  output logic bell
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rcv  <= 1'b0;
      mask <= 1'b0;
      bell <= 1'b0;
    end else begin
      rcv  <= (rcv & ~(loc_we & loc_clr_rcv)) | (rem_we & rem_ring);
      bell <= (bell & ~(rem_we & rem_ack)) | (loc_we & loc_send);
      if (loc_we) mask <= loc_mask_val;
    end
  end

  // R9: one write clears the flag and unmasks
  a_r9_unmask: assert property (@(posedge clk) disable iff (rst)
    (loc_we && loc_clr_rcv && !loc_mask_val && !(rem_we && rem_ring)) |=> (!rcv && !mask));
  // R8: flag holds until cleared by bit 7
  a_r8_flag_hold: assert property (@(posedge clk) disable iff (rst)
    (rcv && !(loc_we && loc_clr_rcv)) |=> rcv);
  // R7: doorbell holds until acknowledged
  a_r7_bell_hold: assert property (@(posedge clk) disable iff (rst)
    (bell && !(rem_we && rem_ack)) |=> bell);
  // R7: send raises doorbell
  a_r7_bell_set: assert property (@(posedge clk) disable iff (rst)
    (loc_we && loc_send) |=> bell);
endmodule

// File: rtl/byte_mailbox.sv
module byte_mailbox
  import mbox_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int BANKS   = NUM_REGS / BANK_W,
  localparam int DATA_SPAN = NUM_REGS * 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic              loc_wr,
  input  logic [BUS_W-1:0]  loc_wdata,
  input  logic              loc_rd,
  output logic [BUS_W-1:0]  loc_rdata,
  input  logic [ADDR_W-1:0] rem_addr,
  input  logic              rem_wr,
  input  logic [BUS_W-1:0]  rem_wdata,
  input  logic              rem_rd,
  output logic [BUS_W-1:0]  rem_rdata,
  output logic              loc_irq,
  output logic              rem_doorbell
);
  logic                loc_in_data, rem_in_data;
  logic [IDX_W-1:0]    loc_idx, rem_idx;
  logic [BYTE_W-1:0]   loc_byte, rem_byte;
  logic [NUM_REGS-1:0] clr_mask, status, enable;
  logic [BANKS-1:0]    en_we;
  logic                pend, rcv, mask;
  logic                loc_lctl_we, rem_rctl_we;
  logic [BUS_W-1:0]    loc_rnext, rem_rnext;
  logic                unused_bits;

  assign unused_bits = ^{loc_wdata[BUS_W-1:BYTE_W], rem_wdata[BUS_W-1:BYTE_W]};

  assign loc_in_data = (int'(loc_addr) < DATA_SPAN) && (loc_addr[1:0] == 2'b00);
  assign rem_in_data = (int'(rem_addr) < DATA_SPAN) && (rem_addr[1:0] == 2'b00);
  assign loc_idx     = loc_addr[IDX_W+1:2];
  assign rem_idx     = rem_addr[IDX_W+1:2];
  assign loc_lctl_we = loc_wr && (loc_addr == OFS_LCTL);
  assign rem_rctl_we = rem_wr && (rem_addr == OFS_RCTL);

  function automatic logic [ADDR_W-1:0] bank_ofs(logic [ADDR_W-1:0] base, int b);
    return base + ADDR_W'(4 * b);
  endfunction

  always_comb begin
    clr_mask = '0;
    en_we    = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (loc_wr && loc_addr == bank_ofs(OFS_STAT, b))
        clr_mask[b*BANK_W +: BANK_W] = loc_wdata[BANK_W-1:0];
      if (loc_wr && loc_addr == bank_ofs(OFS_IEN, b))
        en_we[b] = 1'b1;
    end
  end

  mbox_data_regs #(.NUM_REGS(NUM_REGS), .BYTE_W(BYTE_W)) u_data (
    .clk     (clk),
    .rst     (rst),
    .a_we    (loc_wr && loc_in_data),
    .a_idx   (loc_idx),
    .a_wdata (loc_wdata[BYTE_W-1:0]),
    .b_we    (rem_wr && rem_in_data),
    .b_idx   (rem_idx),
    .b_wdata (rem_wdata[BYTE_W-1:0]),
    .a_rbyte (loc_byte),
    .b_rbyte (rem_byte)
  );

  mbox_irq_status #(.NUM_REGS(NUM_REGS), .BANK_W(BANK_W)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .set_we   (rem_wr && rem_in_data),
    .set_idx  (rem_idx),
    .clr_mask (clr_mask),
    .en_we    (en_we),
    .en_wdata (loc_wdata[BANK_W-1:0]),
    .status   (status),
    .enable   (enable),
    .pend     (pend)
  );

  mbox_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .loc_we       (loc_lctl_we),
    .loc_clr_rcv  (loc_wdata[LCTL_RCV]),
    .loc_mask_val (loc_wdata[LCTL_MASK]),
    .loc_send     (loc_wdata[LCTL_BELL]),
    .rem_we       (rem_rctl_we),
    .rem_ring     (rem_wdata[RCTL_RING]),
    .rem_ack      (rem_wdata[RCTL_ACK]),
    .rcv          (rcv),
    .mask         (mask),
    .bell         (rem_doorbell)
  );

  always_comb begin
    loc_rnext = '0;
    if (loc_in_data) loc_rnext[BYTE_W-1:0] = loc_byte;
    for (int b = 0; b < BANKS; b++) begin
      if (loc_addr == bank_ofs(OFS_STAT, b)) loc_rnext[BANK_W-1:0] = status[b*BANK_W +: BANK_W];
      if (loc_addr == bank_ofs(OFS_IEN, b))  loc_rnext[BANK_W-1:0] = enable[b*BANK_W +: BANK_W];
    end
    if (loc_addr == OFS_LCTL) begin
      loc_rnext[LCTL_RCV]  = rcv;
      loc_rnext[LCTL_MASK] = mask;
      loc_rnext[LCTL_BELL] = rem_doorbell;
    end
    if (loc_addr == OFS_RCTL) begin
      loc_rnext[RCTL_ACK]  = rem_doorbell;
      loc_rnext[RCTL_RING] = rcv;
    end
  end

  always_comb begin
    rem_rnext = '0;
    if (rem_in_data) rem_rnext[BYTE_W-1:0] = rem_byte;
    if (rem_addr == OFS_RCTL) begin
      rem_rnext[RCTL_ACK]  = rem_doorbell;
      rem_rnext[RCTL_RING] = rcv;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_rdata <= '0;
      rem_rdata <= '0;
      loc_irq   <= 1'b0;
    end else begin
      if (loc_rd) loc_rdata <= loc_rnext;
      if (rem_rd) rem_rdata <= rem_rnext;
      loc_irq <= (rcv & ~mask) | pend;
    end
  end

  // R10: no source active means interrupt low next cycle
  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    ((!rcv || mask) && !pend) |=> !loc_irq);
  // R10: enabled status drives interrupt
  a_r10_pend_irq: assert property (@(posedge clk) disable iff (rst)
    pend |=> loc_irq);
  // R2: reserved bytes of message reads are zero
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (loc_rd && loc_in_data) |=> (loc_rdata[BUS_W-1:BYTE_W] == '0));
endmodule

// File: tb/byte_mailbox_test.sv
module byte_mailbox_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  loc_addr = '0, rem_addr = '0;
  logic        loc_wr = 1'b0, loc_rd = 1'b0, rem_wr = 1'b0, rem_rd = 1'b0;
  logic [31:0] loc_wdata = '0, rem_wdata = '0;
  logic [31:0] loc_rdata, rem_rdata;
  logic        loc_irq, rem_doorbell;

  int checks = 0;
  int errors = 0;

  logic [7:0]  mdl_mem [16];
  logic [15:0] mdl_stat, mdl_en;

  always #10 clk = ~clk;

  byte_mailbox uut (
    .clk(clk), .rst(rst),
    .loc_addr(loc_addr), .loc_wr(loc_wr), .loc_wdata(loc_wdata), .loc_rd(loc_rd), .loc_rdata(loc_rdata),
    .rem_addr(rem_addr), .rem_wr(rem_wr), .rem_wdata(rem_wdata), .rem_rd(rem_rd), .rem_rdata(rem_rdata),
    .loc_irq(loc_irq), .rem_doorbell(rem_doorbell)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic lwr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); loc_addr = a; loc_wdata = d; loc_wr = 1'b1;
    @(negedge clk); loc_wr = 1'b0;
  endtask

  task automatic rwr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); rem_addr = a; rem_wdata = d; rem_wr = 1'b1;
    @(negedge clk); rem_wr = 1'b0;
  endtask

  task automatic lrd(logic [6:0] a, output logic [31:0] v);
    @(negedge clk); loc_addr = a; loc_rd = 1'b1;
    @(negedge clk); loc_rd = 1'b0; v = loc_rdata;
  endtask

  task automatic rrd(logic [6:0] a, output logic [31:0] v);
    @(negedge clk); rem_addr = a; rem_rd = 1'b1;
    @(negedge clk); rem_rd = 1'b0; v = rem_rdata;
  endtask

  task automatic both_wr(logic [6:0] la, logic [31:0] ld, logic [6:0] ra, logic [31:0] rd);
    @(negedge clk);
    loc_addr = la; loc_wdata = ld; loc_wr = 1'b1;
    rem_addr = ra; rem_wdata = rd; rem_wr = 1'b1;
    @(negedge clk); loc_wr = 1'b0; rem_wr = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  function automatic logic exp_irq(logic rcv, logic msk, logic [15:0] st, logic [15:0] en);
    return (rcv & ~msk) | (|(st & en));
  endfunction

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int unsigned seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();

    // R1 reset state
    check("R1 irq", {31'b0, loc_irq}, 0);
    check("R1 doorbell", {31'b0, rem_doorbell}, 0);
    lrd(7'h14, v); check("R1 data", v, 0);
    lrd(7'h48, v); check("R1 ctrl", v, 0);

    // R2 placement, reserved bytes, misaligned ignored
    lwr(7'h0C, 32'hABCD_EF5A);
    rrd(7'h0C, v); check("R2 remote view", v, 32'h5A);
    lrd(7'h0C, v); check("R2 local view", v, 32'h5A);
    lwr(7'h0D, 32'h77);
    lrd(7'h0C, v); check("R2 misaligned ignored", v, 32'h5A);
    rwr(7'h3C, 32'h1234_56C3);
    lrd(7'h3C, v); check("R2 last reg", v, 32'hC3);

    // R3 collision: remote wins
    both_wr(7'h08, 32'h11, 7'h08, 32'h22);
    lrd(7'h08, v); check("R3 remote wins", v, 32'h22);

    // R6 enables
    lwr(7'h50, 32'hA5); lwr(7'h54, 32'h3C);
    lrd(7'h50, v); check("R6 enable0", v, 32'hA5);
    lrd(7'h54, v); check("R6 enable1", v, 32'h3C);

    // R4 status set only when enabled and remote
    rwr(7'h04, 32'h01);
    lrd(7'h40, v); check("R4 disabled no status", v, 0);
    check("R10 irq low", {31'b0, loc_irq}, 0);
    lwr(7'h00, 32'h99);
    lrd(7'h40, v); check("R4 local write no status", v, 0);
    rwr(7'h08, 32'h02);
    lrd(7'h40, v); check("R4 status0", v, 32'h04);
    check("R10 irq from status", {31'b0, loc_irq}, 1);
    rwr(7'h30, 32'h03);
    lrd(7'h44, v); check("R4 status1", v, 32'h10);

    // R5 write-one-to-clear
    lwr(7'h40, 32'h00);
    lrd(7'h40, v); check("R5 zero keeps", v, 32'h04);
    lwr(7'h40, 32'h04);
    lrd(7'h40, v); check("R5 clear0", v, 0);
    lwr(7'h44, 32'h10);
    idle();
    check("R10 irq cleared", {31'b0, loc_irq}, 0);
    both_wr(7'h40, 32'h80, 7'h1C, 32'h05);
    lrd(7'h40, v); check("R5 set beats clear", v, 32'h80);
    lwr(7'h40, 32'h80);
    lwr(7'h50, 32'h00); lwr(7'h54, 32'h00);
    idle();

    // R7 doorbell
    lwr(7'h48, 32'h01);
    check("R7 doorbell up", {31'b0, rem_doorbell}, 1);
    rrd(7'h4C, v); check("R11 remote ctrl view", v, 32'h80);
    lrd(7'h48, v); check("R11 local ctrl view", v, 32'h01);
    idle();
    check("R7 doorbell holds", {31'b0, rem_doorbell}, 1);
    rwr(7'h4C, 32'h80);
    check("R7 doorbell acked", {31'b0, rem_doorbell}, 0);

    // R8 / R10 received flag and mask
    rwr(7'h4C, 32'h01);
    check("R10 irq latency", {31'b0, loc_irq}, 0);
    idle();
    check("R10 irq from flag", {31'b0, loc_irq}, 1);
    lrd(7'h48, v); check("R8 flag set", v, 32'h80);
    lwr(7'h48, 32'h02);
    idle();
    check("R10 masked", {31'b0, loc_irq}, 0);
    lrd(7'h48, v); check("R8 mask keeps flag", v, 32'h82);
    rrd(7'h4C, v); check("R11 remote sees flag", v, 32'h01);

    // R9 clear and unmask in one write
    lwr(7'h48, 32'h80);
    lrd(7'h48, v); check("R9 cleared and unmasked", v, 0);
    check("R9 irq low", {31'b0, loc_irq}, 0);
    lwr(7'h48, 32'h02);
    both_wr(7'h48, 32'h80, 7'h4C, 32'h01);
    lrd(7'h48, v); check("R9 ring beats clear", v, 32'h80);
    lwr(7'h48, 32'h80);
    idle();

    // R11 unmapped
    lrd(7'h60, v); check("R11 local unmapped", v, 0);
    rrd(7'h40, v); check("R11 remote no status", v, 0);

    // Random phase
    for (int i = 0; i < 16; i++) begin
      lrd(7'(4 * i), v); mdl_mem[i] = v[7:0];
    end
    mdl_stat = '0;
    mdl_en = 16'($urandom());
    lwr(7'h50, {24'b0, mdl_en[7:0]});
    lwr(7'h54, {24'b0, mdl_en[15:8]});
    for (int n = 0; n < 300; n++) begin
      int r;
      logic [7:0] d;
      r = int'($urandom_range(15, 0));
      d = 8'($urandom());
      if ($urandom_range(1, 0) == 1) begin
        rwr(7'(4 * r), {24'($urandom()), d});
        if (mdl_en[r]) mdl_stat[r] = 1'b1;
      end else begin
        lwr(7'(4 * r), {24'($urandom()), d});
      end
      mdl_mem[r] = d;
    end
    for (int i = 0; i < 16; i++) begin
      lrd(7'(4 * i), v); check("R2 random local", v, {24'b0, mdl_mem[i]});
      rrd(7'(4 * i), v); check("R2 random remote", v, {24'b0, mdl_mem[i]});
    end
    lrd(7'h40, v); check("R4 random status0", v, {24'b0, mdl_stat[7:0]});
    lrd(7'h44, v); check("R4 random status1", v, {24'b0, mdl_stat[15:8]});
    check("R10 random irq", {31'b0, loc_irq}, {31'b0, exp_irq(1'b0, 1'b0, mdl_stat, mdl_en)});
    lwr(7'h40, 32'hFF); lwr(7'h44, 32'hFF);
    idle();
    check("R5 random all cleared", {31'b0, loc_irq}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule